// File: doc/BRIEF.md
# Dual-Address Access Decoder with Write Protection

This block sits behind a two-wire serial slave and turns each addressing step of a transfer into a memory decision. When the slave has received a device address, the block decides whether to acknowledge it. The block answers to a main identity and an auxiliary identity, and it remembers which of the two opened the current transfer. For every byte access that follows, it produces a storage target, a physical byte address and a write strobe. The storage target is the main low space, a page of the main upper space, or the auxiliary space.

The block keeps a live copy of three control locations of the main space. These are the page selector at low offset 7Fh, and the configuration byte and programmable main identity in page 01h at offsets 89h and 8Ch. The block updates each copy as soon as a permitted write lands on it. The configuration byte holds four bits: a single-identity mode, an identity-fix flag, a main lock and an auxiliary lock. The main lock works together with an external write-protect pin. The scratch window at 60h–7Fh of the main low space stays writable at all times.

The storage arrays and the serial bit protocol sit outside the block. A target code of "none" tells the read path to return FFh.

Top module: `ddm_access_map`

## Requirements
- R1: After reset the main identity is A2h. `dev_id` carries bits 7:1 of the address byte, so A2h and A3h both give 51h. A `dev_vld` pulse with 51h is acknowledged. Any identity that matches neither the main nor the auxiliary identity is not acknowledged, and later accesses in that transfer decode to target 0 (none).
- R2: In dual mode (configuration bit 2 = 0), identity A0h (`dev_id` 50h) is acknowledged. Its accesses decode to target 3 (auxiliary), and `out_addr` equals the full byte address.
- R3: A main access below 80h decodes to target 1 (low), with `out_addr` = {0, addr[6:0]}. A main access at 80h or above uses the page selector value. Selector 01h gives target 2 with `out_addr` = {1, addr[6:0]}. Any other selector, including 00h in dual mode, gives target 0 and never a strobe.
- R4: When configuration bit 2 is 1 (single mode), identity A0h is not acknowledged. Selector 00h then gives target 2 with `out_addr` = {0, addr[6:0]}.
- R5: When configuration bit 3 is 1, the main identity is the stored byte at page 01h offset 8Ch, compared on bits 7:1, instead of A2h.
- R6: A main write to the low space below 60h, or to page 01h, is blocked exactly when `wp_pin` = 1 and configuration bit 1 (main lock) = 1.
- R7: Main writes to 60h–7Fh are never blocked, whatever the pin and lock bits are.
- R8: An auxiliary-identity write is blocked whenever configuration bit 0 (auxiliary lock) = 1, whatever `wp_pin` is.
- R9: In single mode, writes to page 00h are blocked exactly when the auxiliary lock is 1. The pin and the main lock have no effect on them.
- R10: Reads never raise `wr_stb`. A blocked write still produces `out_vld` and its target but no strobe.
- R11: The configuration byte changes only on a permitted main write to page 01h offset 89h. Auxiliary writes and blocked writes leave it unchanged.
- R12: `ack` is asserted one cycle after `dev_vld`, for that one cycle only. `out_vld`, `out_tgt`, `out_addr` and `wr_stb` are registered one cycle after `acc_vld`. They are all zero in cycles that follow no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_vld | input | 1 | Device identity received this cycle |
| dev_id | input | 7 | Bits 7:1 of the received address byte |
| acc_vld | input | 1 | Byte access presented this cycle |
| acc_addr | input | 8 | Byte address of the access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 8 | Write data |
| wp_pin | input | 1 | External write-protect level |
| ack | output | 1 | Identity acknowledged |
| out_vld | output | 1 | Access decode result valid |
| out_tgt | output | 2 | 0 none, 1 low, 2 page, 3 auxiliary |
| out_addr | output | 8 | Physical byte address within the target |
| wr_stb | output | 1 | Storage write strobe |

## Verification
The bench walks the lock matrix against a behavioural model. It covers the pin and the main lock together, the auxiliary lock with the pin in both states, and page 00h in single mode with the pin and main lock both high. A design that mixed up these terms would strobe or block the wrong write. The bench tries to clear the main lock while it is locked and then shows that later writes are still blocked, and it writes the configuration offset through the auxiliary identity. A design that snooped every write would unlock itself. The scratch boundary at 5Fh/60h, selector values outside 00h/01h, and the identity switch after programming offset 8Ch are also driven. Off-by-one windows, stray strobes and stale identity compares would each show up as a mismatch on `wr_stb` or `ack`.

// File: rtl/ddm_pkg.sv
package ddm_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_LOW  = 2'd1,
    TGT_PAGE = 2'd2,
    TGT_AUX  = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    SES_IDLE = 2'd0,
    SES_MAIN = 2'd1,
    SES_AUX  = 2'd2
  } ses_e;

  // configuration byte, low nibble: fix, single, main lock, aux lock
  typedef struct packed {
    logic fix;
    logic single;
    logic mlock;
    logic alock;
  } cfg_t;
endpackage

// File: rtl/ddm_cfg_regs.sv
module ddm_cfg_regs
  import ddm_pkg::*;
#(
  parameter int          DW        = 8,
  parameter logic [DW-2:0] CFG_OFS = 7'h09,
  parameter logic [DW-2:0] MID_OFS = 7'h0C,
  parameter logic [DW-2:0] SEL_OFS = 7'h7F,
  parameter logic [DW-1:0] CFG_PG  = 8'h01,
  parameter logic [DW-1:0] MAIN_DEF = 8'hA2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          commit_main,
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output cfg_t          cfg_q,
  output logic [DW-1:0] sel_q,
  output logic [DW-2:0] mid_q
);
  localparam int OW = DW - 1;

  logic hit_sel, hit_cfg, hit_mid, in_cfg_pg;

  assign in_cfg_pg = addr[DW-1] && (sel_q == CFG_PG);
  assign hit_sel   = commit_main && !addr[DW-1] && (addr[OW-1:0] == SEL_OFS);
  assign hit_cfg   = commit_main && in_cfg_pg && (addr[OW-1:0] == CFG_OFS);
  assign hit_mid   = commit_main && in_cfg_pg && (addr[OW-1:0] == MID_OFS);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      sel_q <= '0;
      mid_q <= MAIN_DEF[DW-1:1];
    end else begin
      if (hit_sel) sel_q <= wdata;
      if (hit_cfg) cfg_q <= cfg_t'(wdata[3:0]);
      if (hit_mid) mid_q <= wdata[DW-1:1];
    end
  end
endmodule

// File: rtl/ddm_dev_match.sv
module ddm_dev_match
  import ddm_pkg::*;
#(
  parameter int            DW       = 8,
  parameter logic [DW-1:0] MAIN_DEF = 8'hA2,
  parameter logic [DW-1:0] AUX_ID   = 8'hA0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dev_vld,
  input  logic [DW-2:0] dev_id,
  input  cfg_t          cfg,
  input  logic [DW-2:0] mid,
  output logic          ack,
  output ses_e          sess
);
  logic [DW-2:0] main_id;
  logic          hit_main, hit_aux;

  assign main_id  = cfg.fix ? mid : MAIN_DEF[DW-1:1];
  assign hit_main = (dev_id == main_id);
  assign hit_aux  = !cfg.single && (dev_id == AUX_ID[DW-1:1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ack  <= 1'b0;
      sess <= SES_IDLE;
    end else begin
      ack <= dev_vld && (hit_main || hit_aux);
      if (dev_vld) begin
        if (hit_main)     sess <= SES_MAIN;
        else if (hit_aux) sess <= SES_AUX;
        else              sess <= SES_IDLE;
      end
    end
  end
endmodule

// File: rtl/ddm_decode.sv
module ddm_decode
  import ddm_pkg::*;
#(
  parameter int            DW      = 8,
  parameter logic [DW-2:0] SCR_LO  = 7'h60,
  parameter logic [DW-1:0] CFG_PG  = 8'h01,
  parameter logic [DW-1:0] XTRA_PG = 8'h00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_vld,
  input  logic [DW-1:0] acc_addr,
  input  logic          acc_wr,
  input  ses_e          sess,
  input  cfg_t          cfg,
  input  logic [DW-1:0] sel,
  input  logic          wp,
  output logic          commit,
  output logic          out_vld,
  output tgt_e          out_tgt,
  output logic [DW-1:0] out_addr,
  output logic          wr_stb
);
  localparam int OW = DW - 1;

  tgt_e          tgt;
  logic [DW-1:0] pa;
  logic          blk;
  logic [OW-1:0] ofs;

  assign ofs = acc_addr[OW-1:0];

  always_comb begin
    tgt = TGT_NONE;
    pa  = '0;
    blk = 1'b0;
    case (sess)
      SES_MAIN: begin
        if (!acc_addr[DW-1]) begin
          tgt = TGT_LOW;
          pa  = {1'b0, ofs};
          blk = (ofs < SCR_LO) && wp && cfg.mlock;
        end else if (sel == CFG_PG) begin
          tgt = TGT_PAGE;
          pa  = {1'b1, ofs};
          blk = wp && cfg.mlock;
        end else if (cfg.single && (sel == XTRA_PG)) begin
          tgt = TGT_PAGE;
          pa  = {1'b0, ofs};
          blk = cfg.alock;
        end
      end
      SES_AUX: begin
        tgt = TGT_AUX;
        pa  = acc_addr;
        blk = cfg.alock;
      end
      default: ;
    endcase
  end

  assign commit = acc_vld && acc_wr && (tgt != TGT_NONE) && !blk;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_tgt  <= TGT_NONE;
      out_addr <= '0;
      wr_stb   <= 1'b0;
    end else begin
      out_vld  <= acc_vld;
      out_tgt  <= acc_vld ? tgt : TGT_NONE;
      out_addr <= acc_vld ? pa : '0;
      wr_stb   <= commit;
    end
  end
endmodule

// File: rtl/ddm_access_map.sv
module ddm_access_map
  import ddm_pkg::*;
#(
  parameter int            DW       = 8,
  parameter logic [DW-1:0] MAIN_DEF = 8'hA2,
  parameter logic [DW-1:0] AUX_ID   = 8'hA0,
  parameter logic [DW-2:0] CFG_OFS  = 7'h09,
  parameter logic [DW-2:0] MID_OFS  = 7'h0C,
  parameter logic [DW-2:0] SEL_OFS  = 7'h7F,
  parameter logic [DW-2:0] SCR_LO   = 7'h60,
  parameter logic [DW-1:0] CFG_PG   = 8'h01,
  parameter logic [DW-1:0] XTRA_PG  = 8'h00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dev_vld,
  input  logic [DW-2:0] dev_id,
  input  logic          acc_vld,
  input  logic [DW-1:0] acc_addr,
  input  logic          acc_wr,
  input  logic [DW-1:0] acc_wdata,
  input  logic          wp_pin,
  output logic          ack,
  output logic          out_vld,
  output logic [1:0]    out_tgt,
  output logic [DW-1:0] out_addr,
  output logic          wr_stb
);
  cfg_t          cfg_q;
  logic [DW-1:0] sel_q;
  logic [DW-2:0] mid_q;
  ses_e          sess_q;
  tgt_e          tgt_q;
  logic          commit;

  ddm_cfg_regs #(
    .DW(DW), .CFG_OFS(CFG_OFS), .MID_OFS(MID_OFS), .SEL_OFS(SEL_OFS),
    .CFG_PG(CFG_PG), .MAIN_DEF(MAIN_DEF)
  ) u_cfg (
    .clk(clk), .rst(rst),
    .commit_main(commit && (sess_q == SES_MAIN)),
    .addr(acc_addr), .wdata(acc_wdata),
    .cfg_q(cfg_q), .sel_q(sel_q), .mid_q(mid_q)
  );

  ddm_dev_match #(
    .DW(DW), .MAIN_DEF(MAIN_DEF), .AUX_ID(AUX_ID)
  ) u_match (
    .clk(clk), .rst(rst), .dev_vld(dev_vld), .dev_id(dev_id),
    .cfg(cfg_q), .mid(mid_q), .ack(ack), .sess(sess_q)
  );

  ddm_decode #(
    .DW(DW), .SCR_LO(SCR_LO), .CFG_PG(CFG_PG), .XTRA_PG(XTRA_PG)
  ) u_dec (
    .clk(clk), .rst(rst), .acc_vld(acc_vld), .acc_addr(acc_addr),
    .acc_wr(acc_wr), .sess(sess_q), .cfg(cfg_q), .sel(sel_q),
    .wp(wp_pin), .commit(commit), .out_vld(out_vld), .out_tgt(tgt_q),
    .out_addr(out_addr), .wr_stb(wr_stb)
  );

  assign out_tgt = tgt_q;
endmodule

// File: rtl/ddm_access_map_chk.sv
module ddm_access_map_chk #(
  parameter int            DW     = 8,
  parameter logic [DW-2:0] SCR_LO = 7'h60
) (
  input logic          clk,
  input logic          rst,
  input logic          dev_vld,
  input logic          acc_vld,
  input logic          acc_wr,
  input logic [DW-1:0] acc_addr,
  input logic          wp_pin,
  input logic          ack,
  input logic          out_vld,
  input logic [1:0]    out_tgt,
  input logic [DW-1:0] out_addr,
  input logic          wr_stb,
  input logic [3:0]    cfg_bits,
  input logic [1:0]    sess_bits
);
  AST_ACK_AFTER_ID: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(dev_vld)); // R12

  AST_STB_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $past(acc_vld && acc_wr)); // R10

  AST_STB_HAS_TARGET: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (out_vld && out_tgt != 2'd0)); // R3

  AST_AUX_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && out_tgt == 2'd3) |-> !$past(cfg_bits[0])); // R8

  AST_MAIN_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && ((out_tgt == 2'd1 && out_addr[DW-2:0] < SCR_LO) ||
                (out_tgt == 2'd2 && out_addr[DW-1])))
    |-> !($past(wp_pin) && $past(cfg_bits[1]))); // R6

  AST_SCRATCH_OPEN: assert property (@(posedge clk) disable iff (rst)
    (acc_vld && acc_wr && sess_bits == 2'd1 && !acc_addr[DW-1] &&
     acc_addr[DW-2:0] >= SCR_LO) |=> wr_stb); // R7
endmodule

bind ddm_access_map ddm_access_map_chk #(.DW(DW), .SCR_LO(SCR_LO)) u_chk (
  .clk(clk), .rst(rst), .dev_vld(dev_vld), .acc_vld(acc_vld),
  .acc_wr(acc_wr), .acc_addr(acc_addr), .wp_pin(wp_pin), .ack(ack),
  .out_vld(out_vld), .out_tgt(out_tgt), .out_addr(out_addr),
  .wr_stb(wr_stb), .cfg_bits(cfg_q), .sess_bits(sess_q)
);

// File: tb/test_ddm_access_map.sv
module test_ddm_access_map;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dev_vld = 1'b0;
  logic [6:0] dev_id = '0;
  logic       acc_vld = 1'b0;
  logic [7:0] acc_addr = '0;
  logic       acc_wr = 1'b0;
  logic [7:0] acc_wdata = '0;
  logic       wp_pin = 1'b0;
  logic       ack, out_vld, wr_stb;
  logic [1:0] out_tgt;
  logic [7:0] out_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // behavioural reference state
  int m_sess = 0;      // 0 idle, 1 main, 2 aux
  int m_cfg  = 0;
  int m_sel  = 0;
  int m_mid  = 'hA2;

  always #2 clk = ~clk;

  ddm_access_map i_ddm_access_map (
    .clk(clk), .rst(rst), .dev_vld(dev_vld), .dev_id(dev_id),
    .acc_vld(acc_vld), .acc_addr(acc_addr), .acc_wr(acc_wr),
    .acc_wdata(acc_wdata), .wp_pin(wp_pin), .ack(ack), .out_vld(out_vld),
    .out_tgt(out_tgt), .out_addr(out_addr), .wr_stb(wr_stb)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit dv, int did, bit av, int a, bit w, int wd, string tag);
    int e_ack, e_vld, e_tgt, e_addr, e_stb, main_id;
    bit blk, hm, ha;
    @(negedge clk);
    dev_vld = dv; dev_id = 7'(did);
    acc_vld = av; acc_addr = 8'(a); acc_wr = w; acc_wdata = 8'(wd);
    main_id = ((m_cfg & 8) != 0) ? m_mid : 'hA2;
    hm = dv && (did == (main_id >> 1));
    ha = dv && ((m_cfg & 4) == 0) && (did == ('hA0 >> 1));
    e_ack = (hm || ha) ? 1 : 0;
    e_vld = av ? 1 : 0; e_tgt = 0; e_addr = 0; blk = 0;
    if (av) begin
      if (m_sess == 2) begin
        e_tgt = 3; e_addr = a; blk = (m_cfg & 1) != 0;
      end else if (m_sess == 1) begin
        if (a < 'h80) begin
          e_tgt = 1; e_addr = a;
          blk = (a < 'h60) && wp_pin && ((m_cfg & 2) != 0);
        end else if (m_sel == 1) begin
          e_tgt = 2; e_addr = a;
          blk = wp_pin && ((m_cfg & 2) != 0);
        end else if (m_sel == 0 && (m_cfg & 4) != 0) begin
          e_tgt = 2; e_addr = a - 'h80;
          blk = (m_cfg & 1) != 0;
        end
      end
    end
    e_stb = (av && w && e_tgt != 0 && !blk) ? 1 : 0;
    if (e_stb == 1 && m_sess == 1) begin
      if (e_tgt == 1 && a == 'h7F) m_sel = wd;
      if (e_tgt == 2 && m_sel == 1 && a == 'h89) m_cfg = wd & 'hF;
      if (e_tgt == 2 && m_sel == 1 && a == 'h8C) m_mid = wd;
    end
    if (dv) m_sess = hm ? 1 : (ha ? 2 : 0);
    @(posedge clk); #1;
    chk(tag, "ack", int'(ack), e_ack);
    chk(tag, "out_vld", int'(out_vld), e_vld);
    chk(tag, "out_tgt", int'(out_tgt), e_tgt);
    chk(tag, "out_addr", int'(out_addr), e_addr);
    chk(tag, "wr_stb", int'(wr_stb), e_stb);
  endtask

  task automatic dev(int addr_byte, string tag);
    cyc(1, addr_byte >> 1, 0, 0, 0, 0, tag);
  endtask

  task automatic acc(int a, bit w, int wd, string tag);
    cyc(0, 0, 1, a, w, wd, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk("R1", "reset ack", int'(ack), 0);
    chk("R1", "reset out_vld", int'(out_vld), 0);
    chk("R1", "reset wr_stb", int'(wr_stb), 0);
    @(negedge clk); rst = 1'b0;

    // R1: default main identity, unknown identity
    dev('hA2, "R1");
    cyc(0, 0, 0, 0, 0, 0, "R12");          // ack is a single-cycle pulse
    acc('h00, 0, 0, "R10");
    acc('h10, 1, 'h55, "R6");
    dev('hA3, "R1");
    dev('hA4, "R1");
    acc('h10, 1, 'h11, "R1");
    // R2: auxiliary identity in dual mode
    dev('hA0, "R2");
    acc('hC3, 1, 'h22, "R2");
    acc('h7F, 1, 'h01, "R2");              // aux write, selector unchanged
    // R3: page selection
    dev('hA2, "R3");
    acc('h7F, 1, 'h01, "R3");
    acc('h85, 0, 0, "R3");
    acc('h7F, 1, 'h05, "R3");
    acc('h90, 1, 'h33, "R3");
    acc('h7F, 1, 'h00, "R3");
    acc('h90, 1, 'h33, "R3");
    acc('h7F, 1, 'h01, "R3");
    // R6/R7/R11: main lock with pin
    acc('h89, 1, 'h02, "R6");
    wp_pin = 1'b1;
    acc('h10, 1, 'h44, "R6");
    acc('hA0, 1, 'h44, "R6");
    acc('h60, 1, 'h66, "R7");
    acc('h7F, 1, 'h01, "R7");
    acc('h5F, 1, 'h66, "R7");
    acc('h89, 1, 'h00, "R11");             // blocked attempt to unlock
    acc('h10, 1, 'h44, "R11");
    acc('h10, 0, 0, "R10");
    wp_pin = 1'b0;
    acc('h10, 1, 'h44, "R6");
    acc('h89, 1, 'h00, "R6");
    // R11: config offset written through auxiliary identity
    dev('hA0, "R11");
    acc('h89, 1, 'h02, "R11");
    dev('hA2, "R11");
    wp_pin = 1'b1;
    acc('h10, 1, 'h77, "R11");
    wp_pin = 1'b0;
    // R8: auxiliary lock
    acc('h89, 1, 'h01, "R8");
    dev('hA0, "R8");
    acc('h12, 1, 'h88, "R8");
    wp_pin = 1'b1;
    acc('h12, 1, 'h88, "R8");
    acc('h12, 0, 0, "R10");
    wp_pin = 1'b0;
    // R4/R9: single mode
    dev('hA2, "R4");
    acc('h89, 1, 'h06, "R4");
    dev('hA0, "R4");
    acc('h12, 1, 'h99, "R4");
    dev('hA2, "R4");
    wp_pin = 1'b1;
    acc('h7F, 1, 'h00, "R9");
    acc('h90, 1, 'hAA, "R9");
    acc('h85, 1, 'hAA, "R4");
    wp_pin = 1'b0;
    acc('h7F, 1, 'h01, "R9");
    acc('h89, 1, 'h05, "R9");
    acc('h7F, 1, 'h00, "R9");
    acc('h90, 1, 'hBB, "R9");
    acc('h90, 0, 0, "R10");
    acc('h7F, 1, 'h02, "R3");
    acc('h90, 1, 'hBB, "R3");
    // R5: programmable main identity
    acc('h7F, 1, 'h01, "R5");
    acc('h8C, 1, 'hB4, "R5");
    acc('h89, 1, 'h0C, "R5");
    dev('hB4, "R5");
    acc('h8C, 0, 0, "R5");
    dev('hA2, "R5");
    acc('h10, 1, 'h01, "R5");
    dev('hB5, "R5");
    acc('h89, 1, 'h00, "R5");
    dev('hA2, "R5");
    dev('hA0, "R2");
    cyc(0, 0, 0, 0, 0, 0, "R12");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule